// File: doc/BRIEF.md
# Register Access Command Port

This block sits between a host register bus and a serial register engine. The host writes a 32-bit command word. The block turns it into one 16-bit register read or write and hands it to the engine over a request/acknowledge channel. Progress is shown in a packed status word that the host polls. The status word holds a three-bit state code, a request-pending flag, a sync-idle flag that follows the engine, an init-done flag, and the read data of the most recent read.

A write passes from request to wait-for-idle and then returns straight to idle. A read passes through the same two states but then parks in a wait-for-valid-clear state. The returned data sits there in the status word until the host writes a clear. Commands are taken only from the idle state, and only while the enable register is set. An init-done register lets the host record that configuration is finished.

Host register map (byte offsets, word aligned, bit 0 used for single-bit registers):

- 0x00: enable
- 0x04: init-done
- 0x08: command, write only
- 0x0C: status, read only
- 0x10: valid-clear, write only

A host read returns its data on `hb_rdata` one cycle after `hb_rd`.

Top module: `regcmd_port`

## Requirements
- R1: After reset the state is idle (code 0), enable and init-done read 0, `be_req` is low, and status reads 0 except bit 20, which equals `be_idle`.
- R2: An accepted command word drives the engine with bit 31 as the write flag (`be_write`), bits 30:16 as the halfword address (`be_addr`) and bits 15:0 as the write data (`be_wdata`).
- R3: The status word holds read data in bits 15:0, the state code in bits 18:16, request-pending in bit 19, sync-idle in bit 20 and init-done in bit 21. Bits 31:22 read 0.
- R4: State codes are 0 idle, 2 request, 4 wait-for-idle and 6 wait-for-valid-clear. A write goes 0→2→4→0 and never enters code 6.
- R5: A read goes 0→2→4→6. On leaving code 4 it captures `be_rdata` into status bits 15:0, and that value holds until the next read completes.
- R6: In code 6 only a host write to offset 0x10 with bit 0 set returns the state to idle. Any other write to 0x10 leaves it in code 6.
- R7: A command written while the state is not idle is ignored. It leaves the transfer in progress, its address and data, and the engine request count unchanged.
- R8: While enable (offset 0x00, bit 0) is 0, a command write is ignored and the state stays idle.
- R9: The init-done register (offset 0x04, bit 0) reads back what was written and appears in status bit 21.
- R10: `be_req` is high exactly while the state code is 2. It stays high until `be_ack`, and the engine outputs are stable while it is high.
- R11: Status bit 20 (sync-idle) equals `be_idle` in the cycle the status read is taken, so it is 0 while the engine is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hb_wr | input | 1 | Host register write strobe |
| hb_rd | input | 1 | Host register read strobe |
| hb_addr | input | BUS_AW | Host byte address |
| hb_wdata | input | WORD_W | Host write data |
| hb_rdata | output | WORD_W | Host read data, valid the cycle after `hb_rd` |
| be_req | output | 1 | Request to the serial engine |
| be_write | output | 1 | Request is a write |
| be_addr | output | HADDR_W | Halfword register address |
| be_wdata | output | DATA_W | Register write data |
| be_ack | input | 1 | Engine accepted the request (one-cycle pulse) |
| be_rdata | input | DATA_W | Engine read data, valid when the engine returns to idle |
| be_idle | input | 1 | Engine has no transfer outstanding |

## Verification
The main function is driven by a sweep over every combination of acknowledge latency 0–3 and idle latency 0–3. Each combination issues a write followed by a read of the same address, so the different paths through states 2 and 4 are told apart from timing effects. Extreme address and data values (all zeros, all ones) and reads of never-written addresses separate field-position errors from data-path errors. Commands issued in the request state and in the valid-clear state, valid-clear writes with bit 0 clear, and commands with the enable off show whether ignored stimulus leaks into the engine or the state. A long idle latency exposes the sync-idle flag at 0 during wait-for-idle.

// File: rtl/regcmd_pkg.sv
package regcmd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_REQ       = 3'd2,
    ST_WAIT_IDLE = 3'd4,
    ST_WAIT_VCLR = 3'd6
  } state_e;

  // host register word indices (byte offset / 4)
  localparam int unsigned REG_ENABLE = 0;
  localparam int unsigned REG_INIT   = 1;
  localparam int unsigned REG_CMD    = 2;
  localparam int unsigned REG_STATUS = 3;
  localparam int unsigned REG_VCLR   = 4;
endpackage

// File: rtl/regcmd_csr.sv
module regcmd_csr
  import regcmd_pkg::*;
#(
  parameter int BUS_AW = 5,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hb_wr,
  input  logic              hb_rd,
  input  logic [BUS_AW-1:0] hb_addr,
  input  logic [WORD_W-1:0] hb_wdata,
  input  logic [WORD_W-1:0] status_word,
  output logic              enable_q,
  output logic              init_q,
  output logic              cmd_wr,
  output logic              vclr_wr,
  output logic [WORD_W-1:0] hb_rdata
);
  localparam int IDX_W = BUS_AW - 2;

  logic [IDX_W-1:0] idx;
  logic             aligned;

  assign idx     = hb_addr[BUS_AW-1:2];
  assign aligned = (hb_addr[1:0] == 2'b00);

  assign cmd_wr  = hb_wr && aligned && (idx == IDX_W'(REG_CMD));
  assign vclr_wr = hb_wr && aligned && (idx == IDX_W'(REG_VCLR)) && hb_wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      enable_q <= 1'b0;
      init_q   <= 1'b0;
    end else if (hb_wr && aligned) begin
      if (idx == IDX_W'(REG_ENABLE)) enable_q <= hb_wdata[0];
      if (idx == IDX_W'(REG_INIT))   init_q   <= hb_wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hb_rdata <= '0;
    end else if (hb_rd) begin
      hb_rdata <= '0;
      if (aligned) begin
        if (idx == IDX_W'(REG_ENABLE)) hb_rdata <= {{(WORD_W-1){1'b0}}, enable_q};
        if (idx == IDX_W'(REG_INIT))   hb_rdata <= {{(WORD_W-1){1'b0}}, init_q};
        if (idx == IDX_W'(REG_STATUS)) hb_rdata <= status_word;
      end
    end
  end
endmodule

// File: rtl/regcmd_fsm.sv
module regcmd_fsm
  import regcmd_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int HADDR_W = 15,
  parameter int WORD_W  = 1 + HADDR_W + DATA_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               enable,
  input  logic               cmd_wr,
  input  logic [WORD_W-1:0]  cmd_word,
  input  logic               vclr_wr,
  input  logic               be_ack,
  input  logic               be_idle,
  input  logic [DATA_W-1:0]  be_rdata,
  output state_e             state,
  output logic               be_req,
  output logic               be_write,
  output logic [HADDR_W-1:0] be_addr,
  output logic [DATA_W-1:0]  be_wdata,
  output logic [DATA_W-1:0]  hold_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      be_req    <= 1'b0;
      be_write  <= 1'b0;
      be_addr   <= '0;
      be_wdata  <= '0;
      hold_data <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (enable && cmd_wr) begin
            state    <= ST_REQ;
            be_req   <= 1'b1;
            be_write <= cmd_word[WORD_W-1];
            be_addr  <= cmd_word[WORD_W-2 -: HADDR_W];
            be_wdata <= cmd_word[DATA_W-1:0];
          end
        end
        ST_REQ: begin
          if (be_ack) begin
            state  <= ST_WAIT_IDLE;
            be_req <= 1'b0;
          end
        end
        ST_WAIT_IDLE: begin
          if (be_idle) begin
            if (be_write) begin
              state <= ST_IDLE;
            end else begin
              state     <= ST_WAIT_VCLR;
              hold_data <= be_rdata;
            end
          end
        end
        ST_WAIT_VCLR: begin
          if (vclr_wr) state <= ST_IDLE;
        end
        default: begin
          state  <= ST_IDLE;
          be_req <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/regcmd_port.sv
module regcmd_port
  import regcmd_pkg::*;
#(
  parameter  int DATA_W  = 16,
  parameter  int HADDR_W = 15,
  parameter  int BUS_AW  = 5,
  localparam int WORD_W  = 1 + HADDR_W + DATA_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               hb_wr,
  input  logic               hb_rd,
  input  logic [BUS_AW-1:0]  hb_addr,
  input  logic [WORD_W-1:0]  hb_wdata,
  output logic [WORD_W-1:0]  hb_rdata,
  output logic               be_req,
  output logic               be_write,
  output logic [HADDR_W-1:0] be_addr,
  output logic [DATA_W-1:0]  be_wdata,
  input  logic               be_ack,
  input  logic [DATA_W-1:0]  be_rdata,
  input  logic               be_idle
);
  localparam int PAD_W = WORD_W - DATA_W - 6;

  logic              enable_q;
  logic              init_q;
  logic              cmd_wr;
  logic              vclr_wr;
  state_e            state;
  logic [2:0]        fsm_code;
  logic [DATA_W-1:0] hold_data;
  logic [WORD_W-1:0] status_word;

  assign fsm_code    = state;
  assign status_word = {{PAD_W{1'b0}}, init_q, be_idle, be_req, fsm_code, hold_data};

  regcmd_csr #(.BUS_AW(BUS_AW), .WORD_W(WORD_W)) u_csr (
    .clk         (clk),
    .rst         (rst),
    .hb_wr       (hb_wr),
    .hb_rd       (hb_rd),
    .hb_addr     (hb_addr),
    .hb_wdata    (hb_wdata),
    .status_word (status_word),
    .enable_q    (enable_q),
    .init_q      (init_q),
    .cmd_wr      (cmd_wr),
    .vclr_wr     (vclr_wr),
    .hb_rdata    (hb_rdata)
  );

  regcmd_fsm #(.DATA_W(DATA_W), .HADDR_W(HADDR_W), .WORD_W(WORD_W)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .enable    (enable_q),
    .cmd_wr    (cmd_wr),
    .cmd_word  (hb_wdata),
    .vclr_wr   (vclr_wr),
    .be_ack    (be_ack),
    .be_idle   (be_idle),
    .be_rdata  (be_rdata),
    .state     (state),
    .be_req    (be_req),
    .be_write  (be_write),
    .be_addr   (be_addr),
    .be_wdata  (be_wdata),
    .hold_data (hold_data)
  );
endmodule

// File: rtl/regcmd_chk.sv
module regcmd_chk
  import regcmd_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int HADDR_W = 15,
  parameter int BUS_AW  = 5,
  parameter int WORD_W  = 1 + HADDR_W + DATA_W
) (
  input logic               clk,
  input logic               rst,
  input logic               hb_wr,
  input logic [BUS_AW-1:0]  hb_addr,
  input logic [WORD_W-1:0]  hb_wdata,
  input logic               be_req,
  input logic               be_ack,
  input logic               be_write,
  input logic [HADDR_W-1:0] be_addr,
  input logic [DATA_W-1:0]  be_wdata,
  input logic               be_idle,
  input logic [2:0]         st_code,
  input logic               en
);
  localparam int IDX_W = BUS_AW - 2;

  logic clr_hit;
  assign clr_hit = hb_wr && (hb_addr == {IDX_W'(REG_VCLR), 2'b00}) && hb_wdata[0];

  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (st_code == ST_IDLE) || (st_code == ST_REQ) || (st_code == ST_WAIT_IDLE) || (st_code == ST_WAIT_VCLR)); // R4

  AST_REQ_IN_REQ: assert property (@(posedge clk) disable iff (rst)
    be_req == (st_code == ST_REQ)); // R10

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (be_req && !be_ack) |=> be_req); // R10

  AST_BUSY_FIELDS_STABLE: assert property (@(posedge clk) disable iff (rst)
    (st_code != ST_IDLE) |=> ($stable(be_addr) && $stable(be_wdata) && $stable(be_write))); // R7

  AST_DISABLED_STAYS_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!en && st_code == ST_IDLE) |=> (st_code == ST_IDLE)); // R8

  AST_WRITE_SKIPS_VCLR: assert property (@(posedge clk) disable iff (rst)
    (st_code == ST_WAIT_IDLE && be_write && be_idle) |=> (st_code == ST_IDLE)); // R4

  AST_READ_PARKS: assert property (@(posedge clk) disable iff (rst)
    (st_code == ST_WAIT_IDLE && !be_write && be_idle) |=> (st_code == ST_WAIT_VCLR)); // R5

  AST_VCLR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (st_code == ST_WAIT_VCLR && !clr_hit) |=> (st_code == ST_WAIT_VCLR)); // R6

  AST_VCLR_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (st_code == ST_WAIT_VCLR && clr_hit) |=> (st_code == ST_IDLE)); // R6
endmodule

bind regcmd_port regcmd_chk #(
  .DATA_W(DATA_W), .HADDR_W(HADDR_W), .BUS_AW(BUS_AW), .WORD_W(WORD_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .hb_wr    (hb_wr),
  .hb_addr  (hb_addr),
  .hb_wdata (hb_wdata),
  .be_req   (be_req),
  .be_ack   (be_ack),
  .be_write (be_write),
  .be_addr  (be_addr),
  .be_wdata (be_wdata),
  .be_idle  (be_idle),
  .st_code  (fsm_code),
  .en       (enable_q)
);

// File: tb/regcmd_port_test.sv
module regcmd_port_test;
  localparam int DW = 16;
  localparam int AW = 15;
  localparam int BAW = 5;
  localparam int WW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          hb_wr = 1'b0;
  logic          hb_rd = 1'b0;
  logic [BAW-1:0] hb_addr = '0;
  logic [WW-1:0] hb_wdata = '0;
  logic [WW-1:0] hb_rdata;
  logic          be_req, be_write;
  logic [AW-1:0] be_addr;
  logic [DW-1:0] be_wdata;
  logic          be_ack = 1'b0;
  logic [DW-1:0] be_rdata = '0;
  logic          be_idle = 1'b1;

  int checks = 0;
  int fails = 0;
  int acks = 0;
  int ack_lat = 0;
  int idle_lat = 0;
  logic          seen_write;
  logic [AW-1:0] seen_addr;
  logic [DW-1:0] seen_wdata;
  logic [DW-1:0] mem [int];

  always #10 clk = ~clk; // 50 MHz

  regcmd_port uut (
    .clk(clk), .rst(rst), .hb_wr(hb_wr), .hb_rd(hb_rd), .hb_addr(hb_addr),
    .hb_wdata(hb_wdata), .hb_rdata(hb_rdata), .be_req(be_req), .be_write(be_write),
    .be_addr(be_addr), .be_wdata(be_wdata), .be_ack(be_ack), .be_rdata(be_rdata),
    .be_idle(be_idle)
  );

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
    return {a, 1'b1} ^ 16'h3C3C;
  endfunction

  // serial engine model, acts on falling edges
  initial begin
    int cnt;
    int busy;
    cnt = 0;
    busy = 0;
    forever begin
      @(negedge clk);
      if (be_ack) begin
        be_ack = 1'b0;
        busy = idle_lat;
      end else if (!be_idle) begin
        if (busy == 0) be_idle = 1'b1;
        else busy--;
      end else if (be_req) begin
        if (cnt >= ack_lat) begin
          cnt = 0;
          be_ack = 1'b1;
          be_idle = 1'b0;
          acks++;
          seen_write = be_write;
          seen_addr = be_addr;
          seen_wdata = be_wdata;
          if (be_write) mem[int'(be_addr)] = be_wdata;
          else be_rdata = mem.exists(int'(be_addr)) ? mem[int'(be_addr)] : pat(be_addr);
        end else begin
          cnt++;
        end
      end
    end
  end

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    summary();
  end

  task automatic chk(input string tag, input logic [WW-1:0] act, input logic [WW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic hw(input logic [BAW-1:0] a, input logic [WW-1:0] d);
    hb_addr = a; hb_wdata = d; hb_wr = 1'b1;
    @(negedge clk);
    hb_wr = 1'b0;
  endtask

  task automatic hr(input logic [BAW-1:0] a, output logic [WW-1:0] d);
    hb_addr = a; hb_rd = 1'b1;
    @(negedge clk);
    hb_rd = 1'b0;
    d = hb_rdata;
  endtask

  // issue one command and poll until idle (0) or valid-clear wait (6)
  task automatic do_op(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       output logic [WW-1:0] fin);
    logic [WW-1:0] s;
    int n;
    hw(5'h08, {wr, a, d});
    hr(5'h0C, s);
    chk("R4 first status shows request code 2 with pending bit", {28'd0, s[19:16]}, 32'hA);
    n = 0;
    do begin
      hr(5'h0C, s);
      n++;
      if (s[18:16] != 3'd2 && s[18:16] != 3'd4 && s[18:16] != 3'd0 && s[18:16] != 3'd6)
        chk("R4 legal state code", {29'd0, s[18:16]}, 32'd0);
    end while (s[18:16] != 3'd0 && s[18:16] != 3'd6 && n < 100);
    fin = s;
  endtask

  initial begin
    logic [WW-1:0] s;
    logic [WW-1:0] s2;
    int a0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 be_req low after reset", {31'd0, be_req}, 32'd0);
    hr(5'h00, s); chk("R1 enable reads 0", s, 32'd0);
    hr(5'h04, s); chk("R1 init-done reads 0", s, 32'd0);
    hr(5'h0C, s); chk("R1 R3 status after reset", s, 32'h0010_0000);

    // R8 enable gate
    a0 = acks;
    hw(5'h08, 32'h8123_4567);
    repeat (6) @(negedge clk);
    hr(5'h0C, s); chk("R8 disabled command leaves state idle", {29'd0, s[18:16]}, 32'd0);
    chk("R8 disabled command reaches no engine", acks - a0, 0);
    hw(5'h00, 32'h1);
    hr(5'h00, s); chk("R8 enable reads back 1", s, 32'd1);

    // R9 init-done
    hw(5'h04, 32'h1);
    hr(5'h04, s); chk("R9 init-done reads back 1", s, 32'd1);
    hr(5'h0C, s); chk("R9 R3 init-done in status bit 21", {31'd0, s[21]}, 32'd1);
    chk("R3 upper status bits zero", {22'd0, s[31:22]}, 32'd0);

    // sweep over engine latencies: write then read back
    for (int li = 0; li < 4; li++) begin
      for (int ii = 0; ii < 4; ii++) begin
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        ack_lat = li;
        idle_lat = ii;
        a = AW'((li * 4 + ii) * 1237 + 5);
        d = DW'((li * 4 + ii) * 4099) ^ 16'hA55A;
        do_op(1'b1, a, d, s);
        chk("R4 write ends in idle with sync-idle and init-done", {26'd0, s[21:16]}, 32'h30);
        chk("R2 write flag at engine", {31'd0, seen_write}, 32'd1);
        chk("R2 write address at engine", {17'd0, seen_addr}, {17'd0, a});
        chk("R2 write data at engine", {16'd0, seen_wdata}, {16'd0, d});
        do_op(1'b0, a, 16'hFFFF, s);
        chk("R5 read parks in code 6", {26'd0, s[21:16]}, 32'h36);
        chk("R5 read data in status 15:0", {16'd0, s[15:0]}, {16'd0, d});
        chk("R2 read flag at engine", {31'd0, seen_write}, 32'd0);
        hw(5'h10, 32'h1);
        hr(5'h0C, s2);
        chk("R6 clear returns to idle, data held", s2, {10'd0, 6'h30, d});
      end
    end

    // extremes and unwritten read
    ack_lat = 1; idle_lat = 1;
    do_op(1'b1, 15'h7FFF, 16'hFFFF, s);
    chk("R2 all-ones address at engine", {17'd0, seen_addr}, 32'h7FFF);
    do_op(1'b0, 15'h0000, 16'h0000, s);
    chk("R5 unwritten read returns engine data", {16'd0, s[15:0]}, {16'd0, pat(15'h0)});

    // R6 clear with bit 0 low, and R7 command while parked
    a0 = acks;
    hw(5'h10, 32'h0);
    hw(5'h10, 32'h2);
    hw(5'h08, 32'h8001_BEEF);
    repeat (4) @(negedge clk);
    hr(5'h0C, s2);
    chk("R6 R7 still parked with data unchanged", s2, {10'd0, 6'h36, pat(15'h0)});
    chk("R7 parked command reaches no engine", acks - a0, 0);
    hw(5'h10, 32'h1);
    hr(5'h0C, s2);
    chk("R6 clear releases to idle", {29'd0, s2[18:16]}, 32'd0);

    // R7 command during request, R10 request held, R11 sync-idle low while busy
    ack_lat = 5; idle_lat = 4;
    a0 = acks;
    hw(5'h08, {1'b1, 15'h0123, 16'h1111});
    hw(5'h08, {1'b1, 15'h0456, 16'h2222});
    chk("R10 be_req high during request", {31'd0, be_req}, 32'd1);
    chk("R10 engine address during request", {17'd0, be_addr}, 32'h0123);
    do begin
      hr(5'h0C, s);
    end while (s[18:16] == 3'd2);
    chk("R11 sync-idle low in wait-for-idle", {26'd0, s[21:16]}, 32'h24);
    do begin
      hr(5'h0C, s);
    end while (s[18:16] != 3'd0);
    chk("R7 only first command reached engine", acks - a0, 1);
    chk("R7 first command address kept", {17'd0, seen_addr}, 32'h0123);
    chk("R7 first command data kept", {16'd0, seen_wdata}, 32'h1111);
    chk("R10 be_req low after completion", {31'd0, be_req}, 32'd0);
    chk("R11 sync-idle high when idle", {31'd0, s[20]}, 32'd1);

    summary();
  end
endmodule